// File: doc/BRIEF.md
# Oversampled SPI Slave Transmitter

This block lets a chip answer as an SPI slave on the data-out line without running any logic from the SPI clock. The chip-select and serial-clock pins are treated as ordinary data inputs. A fast system clock samples them through a synchroniser chain, and a rising serial-clock edge is found by comparing two successive samples. Words come in through a plain ready/valid port. They are shifted out most significant bit first, one bit for each detected rising edge, for as long as chip-select stays low.

The first word is loaded as soon as the falling chip-select is seen, so its top bit is already on the line before the master's first rising edge. Each later bit changes a fixed number of system ticks after the rising serial-clock edge. The master samples on its rising edge (mode 0 timing) and relies on that fixed lag for hold time. This works only while the serial clock is slow enough, so the allowed divide ratio is a parameter that is checked against the lag when the design is elaborated. If the source has no word ready at a word boundary, the previous word goes out again and a one-cycle underrun flag is raised.

Top module: `spi_slave_tx`

## Requirements
- R1: After reset, `spi_miso_oe`, `in_ready` and `underrun` are all 0.
- R2: When the synchronised chip-select falls, the first word is loaded, so its MSB is on `spi_miso` before the first rising serial-clock edge.
- R3: Each word leaves MSB first, and each rising serial-clock edge seen while selected advances one bit.
- R4: Words follow each other with no gap. At each word load `in_ready` is high for exactly one cycle, and a word is taken when `in_valid` is high in that cycle.
- R5: If `in_valid` is low at a word load, the previously loaded word is sent again and `underrun` is high for that one cycle.
- R6: While chip-select is high, `spi_miso_oe` is 0. Serial-clock pulses in that time take no word and leave the shift state unchanged.
- R7: `spi_miso` changes on the third system-clock edge after the first edge that samples the serial clock high (`SYNC_STAGES`+1 edges, plus 2 when `PIN_REG`=1).
- R8: A chip-select rise in the middle of a word drops the rest of that word. The next frame starts with the next word from the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip-select pin, active low |
| spi_sck | input | 1 | Serial clock pin, idle low |
| spi_miso | output | 1 | Serial data out value |
| spi_miso_oe | output | 1 | Output enable for the data pin; 0 means undriven |
| in_data | input | WORD_W | Next word to send |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | Pulses at each word load |
| underrun | output | 1 | One-cycle pulse when a load finds no valid word |

## Verification
The checker watches every cycle for these properties: the shift register stepping by one bit on each non-boundary rising edge, the single-cycle `in_ready` pulse, a load on every chip-select fall, an underrun only when nothing was valid, a resent word equal to the last word accepted, and the shift state holding still while deselected. Other behaviours can only be seen at the pins over a whole scenario: serial capture of words across frames, the exact tick at which `spi_miso` changes, glitch pulses while deselected, and a frame cut short in the middle of a word.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

   // Events decoded from the oversampled SPI pins
   typedef struct packed {
      logic cs_low;    // synchronised chip-select is active
      logic cs_fall;   // chip-select has just become active
      logic sck_rise;  // serial clock rose while selected
   } spi_evt_t;

   // System ticks from the first sample of a high serial clock to the MISO update
   function automatic int unsigned tx_latency(input int unsigned stages, input bit pin_reg);
      return stages + 1 + (pin_reg ? 2 : 0);
   endfunction

endpackage

// File: rtl/spi_tx_sampler.sv
module spi_tx_sampler
   import spi_tx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PIN_REG     = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cs_n_pin,
   input  logic     sck_pin,
   output spi_evt_t evt
);

   localparam int unsigned TOP = SYNC_STAGES - 1;

   logic cs_in, sck_in;

   generate
      if (PIN_REG) begin : g_pin_reg
         logic cs_r, sck_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_r  <= 1'b1;
               sck_r <= 1'b0;
            end else begin
               cs_r  <= cs_n_pin;
               sck_r <= sck_pin;
            end
         end
         assign cs_in  = cs_r;
         assign sck_in = sck_r;
      end else begin : g_pin_direct
         assign cs_in  = cs_n_pin;
         assign sck_in = sck_pin;
      end
   endgenerate

   logic [SYNC_STAGES-1:0] cs_q, sck_q;
   logic                   cs_prev, sck_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= '1;
         sck_q    <= '0;
         cs_prev  <= 1'b1;
         sck_prev <= 1'b0;
      end else begin
         cs_q     <= {cs_q[SYNC_STAGES-2:0], cs_in};
         sck_q    <= {sck_q[SYNC_STAGES-2:0], sck_in};
         cs_prev  <= cs_q[TOP];
         sck_prev <= sck_q[TOP];
      end
   end

   always_comb begin
      evt.cs_low   = ~cs_q[TOP];
      evt.cs_fall  = cs_prev & ~cs_q[TOP];
      evt.sck_rise = sck_q[TOP] & ~sck_prev & ~cs_q[TOP];
   end

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
   import spi_tx_pkg::*;
#(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  spi_evt_t          evt,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              underrun,
   output logic [WORD_W-1:0] shreg
);

   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] last_q;
   logic              boundary, load;
   logic [WORD_W-1:0] next_word;

   assign boundary  = evt.sck_rise && (bit_cnt == LAST_BIT);
   assign load      = evt.cs_fall || boundary;
   assign next_word = in_valid ? in_data : last_q;
   assign in_ready  = load;
   assign underrun  = load && !in_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         last_q  <= '0;
         bit_cnt <= '0;
      end else if (load) begin
         shreg   <= next_word;
         bit_cnt <= '0;
         if (in_valid) last_q <= in_data;
      end else if (evt.sck_rise) begin
         shreg   <= {shreg[WORD_W-2:0], 1'b0};
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/spi_slave_tx.sv
module spi_slave_tx
   import spi_tx_pkg::*;
#(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PIN_REG     = 1'b0,
   parameter int unsigned MIN_CLK_DIV = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              underrun
);

   localparam int unsigned LATENCY = tx_latency(SYNC_STAGES, PIN_REG);

   generate
      if (!(WORD_W == 8 || WORD_W == 16)) begin : g_bad_width
         $error("spi_slave_tx: WORD_W must be 8 or 16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_slave_tx: SYNC_STAGES must be at least 2");
      end
      if (MIN_CLK_DIV < 4 || LATENCY >= MIN_CLK_DIV) begin : g_bad_div
         $error("spi_slave_tx: MIN_CLK_DIV must be at least 4 and exceed the data lag");
      end
   endgenerate

   spi_evt_t          evt;
   logic [WORD_W-1:0] shreg;

   spi_tx_sampler #(
      .SYNC_STAGES (SYNC_STAGES),
      .PIN_REG     (PIN_REG)
   ) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_pin (spi_cs_n),
      .sck_pin  (spi_sck),
      .evt      (evt)
   );

   spi_tx_shifter #(
      .WORD_W (WORD_W)
   ) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .underrun (underrun),
      .shreg    (shreg)
   );

   generate
      if (PIN_REG) begin : g_out_reg
         logic miso_q, oe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               miso_q <= 1'b0;
               oe_q   <= 1'b0;
            end else begin
               miso_q <= shreg[WORD_W-1];
               oe_q   <= evt.cs_low;
            end
         end
         assign spi_miso    = miso_q;
         assign spi_miso_oe = oe_q;
      end else begin : g_out_direct
         assign spi_miso    = shreg[WORD_W-1];
         assign spi_miso_oe = evt.cs_low;
      end
   endgenerate

endmodule

// File: rtl/spi_slave_tx_chk.sv
module spi_slave_tx_chk #(
   parameter int unsigned WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_low,
   input logic              cs_fall,
   input logic              sck_rise,
   input logic              in_valid,
   input logic              in_ready,
   input logic              underrun,
   input logic [WORD_W-1:0] in_data,
   input logic [WORD_W-1:0] shreg
);

   // Independent record of the last word accepted through the handshake
   logic [WORD_W-1:0] acc_word;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    acc_word <= '0;
      else if (in_ready && in_valid) acc_word <= in_data;
   end

   a_r2_load_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |-> in_ready);

   a_r3_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_rise && !in_ready) |=> shreg == {$past(shreg[WORD_W-2:0]), 1'b0});

   a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready);

   a_r5_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (in_ready && !in_valid));

   a_r5_resend_last: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> shreg == acc_word);

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_low && !$past(cs_low)) |-> $stable(shreg));

endmodule

bind spi_slave_tx spi_slave_tx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_low   (evt.cs_low),
   .cs_fall  (evt.cs_fall),
   .sck_rise (evt.sck_rise),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .underrun (underrun),
   .in_data  (in_data),
   .shreg    (shreg)
);

// File: tb/tb_spi_slave_tx.sv
`timescale 1ns/1ps
module tb_spi_slave_tx;

   localparam int W    = 8;
   localparam int HALF = 3;   // serial clock = system clock / 6
   localparam int NV   = 10;
   localparam logic [W-1:0] VEC [NV] = '{8'h3C, 8'h81, 8'hF0, 8'h0F, 8'h5A,
                                         8'hC3, 8'h96, 8'hA5, 8'hE7, 8'h42};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic miso, miso_oe, in_ready, underrun, in_valid;
   logic [W-1:0] in_data;

   int idx = 0;
   int n_avail = 0;
   int ur_cnt = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign in_valid = (idx < n_avail);
   assign in_data  = (idx < NV) ? VEC[idx] : '0;

   spi_slave_tx #(.WORD_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_miso(miso), .spi_miso_oe(miso_oe),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .underrun(underrun)
   );

   always @(posedge clk) begin
      if (in_ready && in_valid) idx <= idx + 1;
      if (underrun) ur_cnt <= ur_cnt + 1;
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Master: sample MISO just before each rising edge, then pulse the clock
   task automatic send_bits(input int n, output logic [31:0] cap);
      cap = '0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cap = {cap[30:0], miso};
         if (!miso_oe) begin
            errors++;
            $display("FAIL R6 actual oe 0 expected 1 while selected");
         end
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
         repeat (HALF - 1) @(negedge clk);
      end
   endtask

   task automatic cs_begin();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic cs_end();
      @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] cap;
      repeat (3) @(negedge clk);
      check("R1 oe", miso_oe, 0);
      check("R1 ready", in_ready, 0);
      check("R1 underrun", underrun, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // Frame 1: vector table walked by one loop, then an underrun resend
      n_avail = 6;
      cs_begin();
      for (int k = 0; k < 6; k++) begin
         send_bits(W, cap);
         check($sformatf("R2 R3 R4 word %0d", k), cap[W-1:0], VEC[k]);
      end
      send_bits(W, cap);
      check("R5 resend", cap[W-1:0], VEC[5]);
      @(negedge clk);
      check("R5 underrun count", ur_cnt, 2);
      cs_end();
      check("R6 oe deselected", miso_oe, 0);
      check("R4 words taken", idx, 6);

      // Glitches while deselected
      for (int g = 0; g < 3; g++) begin
         @(negedge clk); sck = 1'b1;
         repeat (2) @(negedge clk); sck = 1'b0;
         repeat (2) @(negedge clk);
      end
      check("R6 glitch no word", idx, 6);
      check("R6 glitch oe", miso_oe, 0);

      // Frame 2: glitch immunity, latency, abort mid-word
      n_avail = 10;
      cs_begin();
      send_bits(W, cap);
      check("R6 first after glitch", cap[W-1:0], VEC[6]);
      @(negedge clk);
      check("R7 msb before edge", miso, 1);
      sck = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R7 held after 2 edges", miso, 1);
      @(negedge clk);
      check("R7 changed after 3 edges", miso, 0);
      sck = 1'b0;
      repeat (HALF - 1) @(negedge clk);
      send_bits(W - 1, cap);
      check("R3 rest of word", cap[W-2:0], VEC[7][W-2:0]);
      send_bits(3, cap);
      check("R8 partial bits", cap[2:0], VEC[8][W-1:W-3]);
      cs_end();

      // Frame 3: next source word after the abort
      cs_begin();
      send_bits(W, cap);
      check("R8 next frame word", cap[W-1:0], VEC[9]);
      @(negedge clk);
      check("R5 final underrun count", ur_cnt, 3);
      cs_end();
      check("R4 final words taken", idx, 10);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule